// File: doc/BRIEF.md
# Packed Byte Alpha Blender

This block mixes two images, a front and a back, one 64-bit beat at a time. Each beat carries eight unsigned 8-bit samples per image. Every sample pair is blended by an 8-bit weight that is shared by all eight lanes. The weight sets how much of the front shows through. A weight of zero leaves the back sample unchanged, and the largest weight gives very nearly the front sample. Each lane uses 16-bit wrap-around fixed-point arithmetic. It forms the difference front minus back and scales it by the weight. It then divides by 255 approximately: it adds half a unit, folds in the high byte, and takes the high byte. The back sample is then added again, and the eight result bytes are packed into one output word.

Beats enter on a valid/ready handshake. A beat is taken on a rising clock edge where `in_valid` and `in_ready` are both high. The sender must hold the front word, the back word and `in_valid` steady until that edge. Results leave on a second valid/ready handshake. While `out_valid` is high and `out_ready` is low, the output word and `out_valid` hold their values. Back-pressure reaches the input within the same cycle: `in_ready` drops only when every pipeline stage is full and the stage ahead cannot move. The weight is a plain register input, and each beat keeps the weight that was present in the cycle it was taken.

Top module: `pkd_alpha_blend`

## Requirements
- R1: Lane i (i = 0..7) occupies bits [8i+7:8i] of `in_front`, `in_back` and `out_pix`. Each output lane depends only on the same lane of the two inputs and on the weight.
- R2: Each lane forms d = (front - back) mod 65536, using both samples zero-extended to 16 bits.
- R3: Each lane forms t = (d * alpha + 0x0080) mod 65536.
- R4: Each lane forms s = (t + (t >> 8)) mod 65536. The output byte is ((s >> 8) + back) mod 256.
- R5: A beat uses the `alpha` value present in the cycle it is accepted. Later changes to `alpha` do not affect beats already inside the pipeline.
- R6: A beat is accepted when `in_valid` and `in_ready` are both high at a rising edge. `in_ready` is high whenever the pipeline can take a beat in that cycle.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_pix` stays stable in the next cycle.
- R8: Every accepted beat leaves exactly once, in order. With `out_ready` held high, a result appears three cycles after its beat is accepted. No more than three beats are in flight at once.
- R9: After reset, `out_valid` is low and `in_ready` is high.
- R10: With alpha = 0x00, every output byte equals its back byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alpha | input | 8 | Blend weight applied to all lanes; sampled when a beat is accepted |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can accept an input beat |
| in_front | input | 64 | Eight packed front samples |
| in_back | input | 64 | Eight packed back samples |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Receiver takes the output beat |
| out_pix | output | 64 | Eight packed blended samples |

## Verification
The bench uses random front and back words, so that negative differences and the wrap in the correction step both occur. These words are paired with the weights 0x00, 0x01, 0x80 and 0xFF, plus random weights; the zero weight exposes any deviation from a pure pass-through of the back sample, and the extreme weights reach the limits of the 16-bit product. Directed words with all-equal, all-maximum and alternating lanes separate a lane swap or a shared carry from correct per-lane arithmetic. The weight is changed on every cycle and the output side is stalled at random. This separates weights that are captured per beat from weights read late, and it separates a correct hold under back-pressure from lost or repeated beats.

// File: rtl/bl_pkg.sv
package bl_pkg;
  localparam int unsigned BL_LANES  = 8;
  localparam int unsigned BL_SAMP_W = 8;
  localparam int unsigned BL_DEPTH  = 3;
endpackage

// File: rtl/bl_stage.sv
module bl_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         v_q;
  logic [W-1:0] d_q;

  assign in_ready  = !v_q || out_ready;
  assign out_valid = v_q;
  assign out_data  = d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      d_q <= '0;
    end else if (in_ready) begin
      v_q <= in_valid;
      if (in_valid) d_q <= in_data;
    end
  end

  // R7: a stalled stage keeps its beat and its contents
  a_r7_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
  a_r7_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data));
endmodule

// File: rtl/bl_lane_sub.sv
module bl_lane_sub #(
  parameter int unsigned SAMP_W = 8,
  localparam int unsigned WIDE_W = 2 * SAMP_W
) (
  input  logic [SAMP_W-1:0] front,
  input  logic [SAMP_W-1:0] back,
  output logic [WIDE_W-1:0] diff
);
  // R2: wrapping difference of the zero-extended samples
  assign diff = {{SAMP_W{1'b0}}, front} - {{SAMP_W{1'b0}}, back};
endmodule

// File: rtl/bl_lane_mac.sv
module bl_lane_mac #(
  parameter int unsigned SAMP_W = 8,
  localparam int unsigned WIDE_W = 2 * SAMP_W
) (
  input  logic [WIDE_W-1:0] diff,
  input  logic [SAMP_W-1:0] weight,
  output logic [WIDE_W-1:0] scaled
);
  localparam logic [WIDE_W-1:0] HALF = WIDE_W'(1) << (SAMP_W - 1);
  logic [WIDE_W-1:0] prod;

  // R3: product kept to the wide width, then the half-unit round term
  assign prod   = diff * {{SAMP_W{1'b0}}, weight};
  assign scaled = prod + HALF;
endmodule

// File: rtl/bl_lane_fix.sv
module bl_lane_fix #(
  parameter int unsigned SAMP_W = 8,
  localparam int unsigned WIDE_W = 2 * SAMP_W
) (
  input  logic [WIDE_W-1:0] scaled,
  input  logic [SAMP_W-1:0] back,
  output logic [SAMP_W-1:0] result
);
  logic [WIDE_W-1:0] folded;

  // R4: fold the high part back in, keep the high part, re-add back
  assign folded = scaled + {{SAMP_W{1'b0}}, scaled[WIDE_W-1:SAMP_W]};
  assign result = folded[WIDE_W-1:SAMP_W] + back;
endmodule

// File: rtl/pkd_alpha_blend.sv
module pkd_alpha_blend #(
  parameter int unsigned LANES  = bl_pkg::BL_LANES,
  parameter int unsigned SAMP_W = bl_pkg::BL_SAMP_W,
  localparam int unsigned WIDE_W = 2 * SAMP_W,
  localparam int unsigned BEAT_W = LANES * SAMP_W,
  localparam int unsigned DIFF_W = LANES * WIDE_W,
  localparam int unsigned P1_W   = DIFF_W + BEAT_W + SAMP_W,
  localparam int unsigned P2_W   = DIFF_W + BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SAMP_W-1:0] alpha,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BEAT_W-1:0] in_front,
  input  logic [BEAT_W-1:0] in_back,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BEAT_W-1:0] out_pix
);
  localparam int unsigned CNT_W = $clog2(bl_pkg::BL_DEPTH + 1) + 1;

  // stage 1: differences, back word and captured weight
  logic [DIFF_W-1:0] s1_diff_d, s1_diff;
  logic [BEAT_W-1:0] s1_back;
  logic [SAMP_W-1:0] s1_alpha;
  logic [P1_W-1:0]   s1_q;
  logic              s1_valid, s1_ready;

  // stage 2: scaled values and back word
  logic [DIFF_W-1:0] s2_scaled_d, s2_scaled;
  logic [BEAT_W-1:0] s2_back;
  logic [P2_W-1:0]   s2_q;
  logic              s2_valid, s2_ready;

  // stage 3: packed result
  logic [BEAT_W-1:0] s3_pix_d;

  for (genvar i = 0; i < LANES; i++) begin : g_sub
    bl_lane_sub #(.SAMP_W(SAMP_W)) u_sub (
      .front (in_front[i*SAMP_W +: SAMP_W]),
      .back  (in_back[i*SAMP_W +: SAMP_W]),
      .diff  (s1_diff_d[i*WIDE_W +: WIDE_W])
    );
  end

  bl_stage #(.W(P1_W)) u_st1 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   ({s1_diff_d, in_back, alpha}),
    .out_valid (s1_valid),
    .out_ready (s1_ready),
    .out_data  (s1_q)
  );
  assign {s1_diff, s1_back, s1_alpha} = s1_q;

  for (genvar i = 0; i < LANES; i++) begin : g_mac
    bl_lane_mac #(.SAMP_W(SAMP_W)) u_mac (
      .diff   (s1_diff[i*WIDE_W +: WIDE_W]),
      .weight (s1_alpha),
      .scaled (s2_scaled_d[i*WIDE_W +: WIDE_W])
    );
  end

  bl_stage #(.W(P2_W)) u_st2 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (s1_valid),
    .in_ready  (s1_ready),
    .in_data   ({s2_scaled_d, s1_back}),
    .out_valid (s2_valid),
    .out_ready (s2_ready),
    .out_data  (s2_q)
  );
  assign {s2_scaled, s2_back} = s2_q;

  for (genvar i = 0; i < LANES; i++) begin : g_fix
    bl_lane_fix #(.SAMP_W(SAMP_W)) u_fix (
      .scaled (s2_scaled[i*WIDE_W +: WIDE_W]),
      .back   (s2_back[i*SAMP_W +: SAMP_W]),
      .result (s3_pix_d[i*SAMP_W +: SAMP_W])
    );
  end

  bl_stage #(.W(BEAT_W)) u_st3 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (s2_valid),
    .in_ready  (s2_ready),
    .in_data   (s3_pix_d),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_pix)
  );

  // occupancy tracked at the ports, for the checks below
  logic [CNT_W-1:0] inflight_q;
  logic             take_in, take_out;
  assign take_in  = in_valid && in_ready;
  assign take_out = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) inflight_q <= '0;
    else if (take_in && !take_out) inflight_q <= inflight_q + 1'b1;
    else if (take_out && !take_in) inflight_q <= inflight_q - 1'b1;
  end

  // R8: never more beats inside than stages
  a_r8_inflight_bound: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_q <= CNT_W'(bl_pkg::BL_DEPTH));
  // R8: no result without an accepted beat behind it
  a_r8_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (inflight_q != '0));
  // R5: the accepted beat carries the weight of its acceptance cycle
  a_r5_alpha_capture: assert property (@(posedge clk) disable iff (!rst_n)
    take_in |=> (s1_alpha == $past(alpha)));
  // R6: an empty pipeline always offers ready
  a_r6_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight_q == '0) |-> in_ready);
endmodule

// File: tb/pkd_alpha_blend_tb.sv
module pkd_alpha_blend_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  alpha = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_front = '0;
  logic [63:0] in_back = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_pix;

  int errors = 0;
  int checks = 0;
  int cycle  = 0;

  always #5 clk = ~clk;

  pkd_alpha_blend u_dut (
    .clk(clk), .rst_n(rst_n), .alpha(alpha),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_front(in_front), .in_back(in_back),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
  );

  function automatic logic [63:0] ref_blend(logic [63:0] f, logic [63:0] b, logic [7:0] a);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) begin
      logic [15:0] d, t, s;
      d = {8'h00, f[i*8 +: 8]} - {8'h00, b[i*8 +: 8]};
      t = d * {8'h00, a} + 16'h0080;
      s = t + (t >> 8);
      r[i*8 +: 8] = s[15:8] + b[i*8 +: 8];
    end
    return r;
  endfunction

  function automatic logic [7:0] pick_alpha();
    case ($urandom_range(0, 4))
      0: return 8'h00;
      1: return 8'h01;
      2: return 8'h80;
      3: return 8'hFF;
      default: return 8'($urandom);
    endcase
  endfunction

  task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard
  logic [63:0] exp_q[$];
  logic [63:0] bk_q[$];
  logic [7:0]  al_q[$];
  int          stamp_q[$];
  bit          free_flow = 1'b0;
  bit          prev_stall = 1'b0;
  logic [63:0] prev_pix = '0;
  bit          done = 1'b0;

  // one bus cycle: drive at negedge, observe the transfer at the next edge
  task automatic bus_cycle(bit v, logic [63:0] f, logic [63:0] b, logic [7:0] a, bit rdy);
    @(negedge clk);
    cycle++;
    in_valid = v; in_front = f; in_back = b; alpha = a; out_ready = rdy;
    #1;
    if (prev_stall) begin
      // R7: held beat stays valid with the same word
      check64("R7 hold valid", {63'd0, out_valid}, 64'd1);
      check64("R7 hold data", out_pix, prev_pix);
    end
    if (in_valid && in_ready) begin
      exp_q.push_back(ref_blend(f, b, a));
      bk_q.push_back(b);
      al_q.push_back(a);
      stamp_q.push_back(cycle);
    end
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        errors++; checks++;
        $display("FAIL R8 unexpected beat: actual=%h expected=none", out_pix);
      end else begin
        logic [63:0] e, bk;
        logic [7:0]  al;
        int st;
        e = exp_q.pop_front(); bk = bk_q.pop_front();
        al = al_q.pop_front(); st = stamp_q.pop_front();
        // R1 R2 R3 R4 R5: per-lane arithmetic with the weight of acceptance
        check64("R1-lanes/R4 blend R5", out_pix, e);
        if (al == 8'h00) check64("R10 zero weight", out_pix, bk);
        if (free_flow) check64("R8 latency", 64'(cycle - st), 64'd3);
      end
    end
    prev_stall = out_valid && !out_ready;
    prev_pix = out_pix;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    // R9: reset state
    check64("R9 out_valid in reset", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check64("R9 out_valid after reset", {63'd0, out_valid}, 64'd0);
    check64("R9 in_ready after reset", {63'd0, in_ready}, 64'd1);

    // R8: single beat latency with free flow
    free_flow = 1'b1;
    bus_cycle(1'b1, 64'h0102030405060708, 64'h0807060504030201, 8'h80, 1'b1);
    for (int k = 0; k < 4; k++) bus_cycle(1'b0, '0, '0, 8'h33, 1'b1);

    // directed corners: equal lanes, extremes, alternating lanes
    bus_cycle(1'b1, 64'hFFFFFFFFFFFFFFFF, 64'h0000000000000000, 8'hFF, 1'b1);
    bus_cycle(1'b1, 64'h0000000000000000, 64'hFFFFFFFFFFFFFFFF, 8'hFF, 1'b1);
    bus_cycle(1'b1, 64'h5A5A5A5A5A5A5A5A, 64'h5A5A5A5A5A5A5A5A, 8'h80, 1'b1);
    bus_cycle(1'b1, 64'hFF00FF00FF00FF00, 64'h00FF00FF00FF00FF, 8'h01, 1'b1);
    bus_cycle(1'b1, 64'h123456789ABCDEF0, 64'h0FEDCBA987654321, 8'h00, 1'b1);
    bus_cycle(1'b1, 64'h80808080807F7F7F, 64'h7F7F7F7F7F808080, 8'hFF, 1'b1);
    for (int k = 0; k < 5; k++) bus_cycle(1'b0, '0, '0, 8'($urandom), 1'b1);

    // free-flowing random stream, weight changes every cycle
    for (int k = 0; k < 400; k++)
      bus_cycle(1'b1, {$urandom, $urandom}, {$urandom, $urandom}, pick_alpha(), 1'b1);
    for (int k = 0; k < 5; k++) bus_cycle(1'b0, '0, '0, 8'($urandom), 1'b1);

    // random valid and back-pressure (R6 R7 R8)
    free_flow = 1'b0;
    for (int k = 0; k < 2000; k++)
      bus_cycle(($urandom_range(0, 3) != 0), {$urandom, $urandom}, {$urandom, $urandom},
                pick_alpha(), ($urandom_range(0, 2) != 0));
    for (int k = 0; k < 20; k++) bus_cycle(1'b0, '0, '0, 8'($urandom), 1'b1);

    // R8: every accepted beat came out
    check64("R8 drained", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
  end

  initial begin
    int wd;
    wd = 0;
    while (!done && wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", wd);
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule